// File: doc/BRIEF.md
# Dual-Compare 8-Bit Event Timer

This block is an 8-bit up-counter with two compare registers. Every time the counter advances onto the value held in either compare register, a match event is raised. Each match can set a status flag that may request an interrupt, and can change the level on a single timer output pin. The two matches have separate output actions, so one compare can set the leading edge of a pulse and the other its trailing edge. The counter can also be cleared by compare A, by compare B, or by an external reset input.

The count source is chosen by a control field. It can be one of several prescaled tick enables that come from outside the block, or rising, falling or both edges of an external event input. The external event, reset and trigger inputs each pass through a two-flop synchronizer before their edges are detected. When trigger gating is on, the counter holds until the trigger input rises. This lets a pulse of set width start at a set delay after an external event.

Software reaches every register through a simple single-cycle register port. Writes take effect at the clock edge. Read data is combinational from the address. Flags clear only through a read-then-write-zero sequence, which keeps a flag that is set between the read and the write from being lost.

Top module: `evt_timer8`

## Requirements
- R1: After reset every register reads 0, `tmr_out` is 0 and `irq` is 0. Register addresses are: 0 counter, 1 compare A, 2 compare B, 3 control, 4 output control, 5 interrupt enable, 6 flags. `reg_rdata` follows `reg_addr` without delay.
- R2: On each selected tick the counter rises by one. On a tick at 8'hFF it wraps to 8'h00 and sets the overflow flag (flags bit 2).
- R3: When control bits [4:3] are 01 and the counter would advance onto compare A, it loads 0 instead, so it cycles with period equal to compare A.
- R4: When control bits [4:3] are 10, the same clearing happens on compare B.
- R5: When control bits [4:3] are 11, a synchronized rising edge on `ext_rst` clears the counter. In any other clear mode, `ext_rst` has no effect on the counter.
- R6: Output control bits [1:0] give the action for match A and bits [3:2] the action for match B. The encoding is 00 hold, 01 drive low, 10 drive high, 11 toggle. When both matches occur in the same cycle, the B action is applied after the A action.
- R7: After reset, `tmr_out` stays 0 until the first compare match.
- R8: Match A sets flags bit 0 and match B sets flags bit 1. `irq` is high while any flag is set whose enable bit is also set. The enable bits are: bit 0 for A, bit 1 for B, bit 2 for overflow.
- R9: A flag clears only when flags is read while the flag is 1 and a later write puts 0 in that bit. Writing 1, or writing 0 without a prior read, leaves the flag unchanged.
- R10: A software write to the counter wins over an increment or a clear in the same cycle.
- R11: With control bit 5 set, the counter holds until `ext_trig` rises. The first count happens on the fourth rising `clk` edge after `ext_trig` goes high.
- R12: Control bits [2:0] select the count source: 0 stopped; 1 to 4 select `int_tick[0]` to `int_tick[3]`; 5 selects rising edges of `ext_clk`; 6 selects falling edges; 7 selects both edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe (used to arm flag clearing) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, combinational from the address |
| int_tick | input | 4 | Prescaled internal count enables |
| ext_clk | input | 1 | External event input to count |
| ext_rst | input | 1 | External counter-clear input |
| ext_trig | input | 1 | External start trigger |
| tmr_out | output | 1 | Timer output pin |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check these rules on every cycle:
- the write-wins priority and the clear-on-compare-A load;
- the wrap to zero on overflow;
- the output holding its level with no match, and staying 0 until the first match;
- flags surviving a write of 1 or an unarmed write of 0;
- synchronized edges lasting exactly one cycle.

Only the bench's scenarios can show the rest. These cover count periods under random compare values and random start points, the priority when both matches occur together, the latency from a trigger to the first count, and exact counts of external edges for each edge mode.

// File: rtl/evt_timer8_pkg.sv
package evt_timer8_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD = 2'b00,
    ACT_LOW  = 2'b01,
    ACT_HIGH = 2'b10,
    ACT_TOG  = 2'b11
  } out_act_e;

  typedef enum logic [1:0] {
    CLR_NONE = 2'b00,
    CLR_CMPA = 2'b01,
    CLR_CMPB = 2'b10,
    CLR_EXT  = 2'b11
  } clr_sel_e;

  localparam logic [2:0] A_CNT  = 3'd0;
  localparam logic [2:0] A_CMPA = 3'd1;
  localparam logic [2:0] A_CMPB = 3'd2;
  localparam logic [2:0] A_CTRL = 3'd3;
  localparam logic [2:0] A_OUTC = 3'd4;
  localparam logic [2:0] A_IEN  = 3'd5;
  localparam logic [2:0] A_FLG  = 3'd6;

  localparam int NFLAG = 3;

  // new pin level after one output action
  function automatic logic apply_act(input logic cur, input logic [1:0] act);
    case (out_act_e'(act))
      ACT_LOW:  return 1'b0;
      ACT_HIGH: return 1'b1;
      ACT_TOG:  return ~cur;
      default:  return cur;
    endcase
  endfunction

  // counter successor, wrapping at the top
  function automatic logic [7:0] next_count(input logic [7:0] c);
    return c + 8'd1;
  endfunction

endpackage

// File: rtl/evt_sync_edge.sv
module evt_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES:0] chain;

  genvar g;
  generate
    for (g = 0; g <= STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[g] <= 1'b0;
          else        chain[g] <= chain[g-1];
      end
    end
  endgenerate

  assign rise = chain[STAGES-1] & ~chain[STAGES];
  assign fall = ~chain[STAGES-1] & chain[STAGES];

  AST_RISE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R5
  AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R12
endmodule

// File: rtl/evt_flag_bit.sv
module evt_flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic rd,
  input  logic wr,
  input  logic wbit,
  output logic q
);
  logic arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= 1'b0;
      arm <= 1'b0;
    end else begin
      if (set)                     q <= 1'b1;
      else if (wr && !wbit && arm) q <= 1'b0;
      if (wr)                      arm <= 1'b0;
      else if (rd && q)            arm <= 1'b1;
    end
  end

  AST_FLAG_GUARDED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (wbit || !arm) && !set) |=> $stable(q)); // R9
  AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> q); // R8
endmodule

// File: rtl/evt_out_ctl.sv
module evt_out_ctl
  import evt_timer8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match_a,
  input  logic       match_b,
  input  logic [1:0] act_a,
  input  logic [1:0] act_b,
  output logic       pin
);
  logic after_a, after_b;

  always_comb begin
    after_a = match_a ? apply_act(pin, act_a) : pin;
    after_b = match_b ? apply_act(after_a, act_b) : after_a;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pin <= 1'b0;
    else        pin <= after_b;

  AST_OUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !(match_a || match_b) |=> $stable(pin)); // R6
endmodule

// File: rtl/evt_timer8.sv
module evt_timer8
  import evt_timer8_pkg::*;
#(
  parameter int W     = 8,
  parameter int NTICK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic             reg_re,
  input  logic [2:0]       reg_addr,
  input  logic [W-1:0]     reg_wdata,
  output logic [W-1:0]     reg_rdata,
  input  logic [NTICK-1:0] int_tick,
  input  logic             ext_clk,
  input  logic             ext_rst,
  input  logic             ext_trig,
  output logic             tmr_out,
  output logic             irq
);
  localparam int SYNC = 2;

  logic [W-1:0] cnt, cmp_a, cmp_b, cnt_inc;
  logic [7:0]   ctrl;
  logic [3:0]   outc;
  logic [NFLAG-1:0] ien, flags, flag_set;

  logic [2:0] clk_sel;
  clr_sel_e   clr_sel;
  logic       trig_en;
  assign clk_sel = ctrl[2:0];
  assign clr_sel = clr_sel_e'(ctrl[4:3]);
  assign trig_en = ctrl[5];

  // synchronized external events
  logic eclk_rise, eclk_fall, erst_rise, erst_fall, trig_rise, trig_fall;
  evt_sync_edge #(.STAGES(SYNC)) u_sync_clk (.clk(clk), .rst_n(rst_n), .din(ext_clk),
    .rise(eclk_rise), .fall(eclk_fall));
  evt_sync_edge #(.STAGES(SYNC)) u_sync_rst (.clk(clk), .rst_n(rst_n), .din(ext_rst),
    .rise(erst_rise), .fall(erst_fall));
  evt_sync_edge #(.STAGES(SYNC)) u_sync_trg (.clk(clk), .rst_n(rst_n), .din(ext_trig),
    .rise(trig_rise), .fall(trig_fall));

  // count source selection
  logic tick;
  always_comb begin
    tick = 1'b0;
    case (clk_sel)
      3'd5: tick = eclk_rise;
      3'd6: tick = eclk_fall;
      3'd7: tick = eclk_rise | eclk_fall;
      default:
        for (int i = 0; i < NTICK; i++)
          if (clk_sel == 3'(i + 1)) tick = int_tick[i];
    endcase
  end

  // trigger gate
  logic started;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         started <= 1'b0;
    else if (!trig_en)  started <= 1'b0;
    else if (trig_rise) started <= 1'b1;

  // named internal events
  logic run, match_a, match_b, ovf_evt, clr_evt, cnt_we;
  assign run      = tick && (!trig_en || started);
  assign cnt_inc  = next_count(cnt);
  assign match_a  = run && (cnt_inc == cmp_a);
  assign match_b  = run && (cnt_inc == cmp_b);
  assign ovf_evt  = run && (cnt == {W{1'b1}});
  assign clr_evt  = (clr_sel == CLR_CMPA && match_a) ||
                    (clr_sel == CLR_CMPB && match_b) ||
                    (clr_sel == CLR_EXT  && erst_rise);
  assign cnt_we   = reg_we && (reg_addr == A_CNT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; cmp_a <= '0; cmp_b <= '0;
      ctrl <= '0; outc <= '0; ien <= '0;
    end else begin
      if (cnt_we)       cnt <= reg_wdata;
      else if (clr_evt) cnt <= '0;
      else if (run)     cnt <= cnt_inc;
      if (reg_we) begin
        case (reg_addr)
          A_CMPA:  cmp_a <= reg_wdata;
          A_CMPB:  cmp_b <= reg_wdata;
          A_CTRL:  ctrl  <= reg_wdata[7:0];
          A_OUTC:  outc  <= reg_wdata[3:0];
          A_IEN:   ien   <= reg_wdata[NFLAG-1:0];
          default: ;
        endcase
      end
    end
  end

  // status flags
  assign flag_set = {ovf_evt, match_b, match_a};
  genvar f;
  generate
    for (f = 0; f < NFLAG; f++) begin : g_flag
      evt_flag_bit u_flag (
        .clk(clk), .rst_n(rst_n), .set(flag_set[f]),
        .rd(reg_re && reg_addr == A_FLG), .wr(reg_we && reg_addr == A_FLG),
        .wbit(reg_wdata[f]), .q(flags[f]));
    end
  endgenerate

  assign irq = |(flags & ien);

  evt_out_ctl u_out (.clk(clk), .rst_n(rst_n), .match_a(match_a), .match_b(match_b),
    .act_a(outc[1:0]), .act_b(outc[3:2]), .pin(tmr_out));

  always_comb begin
    case (reg_addr)
      A_CNT:   reg_rdata = cnt;
      A_CMPA:  reg_rdata = cmp_a;
      A_CMPB:  reg_rdata = cmp_b;
      A_CTRL:  reg_rdata = W'(ctrl);
      A_OUTC:  reg_rdata = W'(outc);
      A_IEN:   reg_rdata = W'(ien);
      A_FLG:   reg_rdata = W'(flags);
      default: reg_rdata = '0;
    endcase
  end

  // assertion support: has any match happened since reset
  logic seen_match;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   seen_match <= 1'b0;
    else if (match_a || match_b)  seen_match <= 1'b1;

  AST_OUT_QUIET_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_match |-> !tmr_out); // R7
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_we |=> cnt == $past(reg_wdata)); // R10
  AST_CLEAR_ON_A: assert property (@(posedge clk) disable iff (!rst_n)
    (match_a && clr_sel == CLR_CMPA && !cnt_we) |=> cnt == '0); // R3
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !cnt_we && !clr_evt) |=> cnt == '0); // R2
endmodule

// File: tb/evt_timer8_test.sv
`timescale 1ns/1ps
module evt_timer8_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic we = 1'b0, re = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic [3:0] tick = 4'b0001;
  logic eclk = 1'b0, erst = 1'b0, etrig = 1'b0;
  logic tout, irq;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evt_timer8 uut (.clk(clk), .rst_n(rst_n), .reg_we(we), .reg_re(re), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .int_tick(tick), .ext_clk(eclk),
    .ext_rst(erst), .ext_trig(etrig), .tmr_out(tout), .irq(irq));

  function automatic int exp_period(int k, int p); return k % p; endfunction
  function automatic int exp_wrap(int s, int k); return (s + k) & 255; endfunction
  function automatic int exp_toggle(int k, int p); return (k / p) & 1; endfunction

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic peek(logic [2:0] a, output int d);
    addr = a; #1 d = int'(rdata);
  endtask

  task automatic rd_flags(output int d);
    @(negedge clk); addr = 3'd6; re = 1'b1; #1 d = int'(rdata);
    @(negedge clk); re = 1'b0;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int v, p, k, s, t;
    v = $urandom(32'h5EED_0017);
    step(3); rst_n = 1'b1; step(1);

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      peek(3'(a), v); check("R1 reg", v, 0);
    end
    check("R1 tmr_out", int'(tout), 0);
    check("R1 irq", int'(irq), 0);

    // R7 output quiet before any match
    wr(3'd1, 8'd200); wr(3'd2, 8'd201); wr(3'd4, 8'b1010); wr(3'd3, 8'h01);
    step(50);
    check("R7 out before match", int'(tout), 0);
    wr(3'd3, 8'h00);

    // R2 wrap and overflow flag
    wr(3'd0, 8'd250); wr(3'd3, 8'h01); step(10);
    peek(3'd0, v); check("R2 wrap", v, exp_wrap(250, 10));
    rd_flags(v); check("R2 overflow flag", v, 4);
    wr(3'd3, 8'h00);

    // R9 clearing protocol (counter stopped)
    wr(3'd6, 8'hFF); peek(3'd6, v); check("R9 write one keeps", v, 4);
    wr(3'd6, 8'h00); peek(3'd6, v); check("R9 unarmed zero keeps", v, 4);
    rd_flags(v); wr(3'd6, 8'h00); peek(3'd6, v); check("R9 read then zero clears", v, 0);
    check("R8 irq disabled", int'(irq), 0);

    // R6 / R8 / R4 set on A, clear on B
    wr(3'd4, 8'b0110); wr(3'd1, 8'd5); wr(3'd2, 8'd10); wr(3'd5, 8'b001);
    wr(3'd0, 8'd0); wr(3'd3, 8'h11);
    step(7);
    check("R6 high on A", int'(tout), 1);
    check("R8 irq on A", int'(irq), 1);
    step(5);
    check("R6 low on B", int'(tout), 0);
    peek(3'd0, v); check("R4 clear on B", v, 2);
    wr(3'd3, 8'h00);
    rd_flags(v); wr(3'd6, 8'h00);
    check("R8 irq after clear", int'(irq), 0);

    // R6 toggle on A with clear on A
    wr(3'd4, 8'b0011); wr(3'd1, 8'd4); wr(3'd0, 8'd0); wr(3'd3, 8'h09);
    step(6);  check("R6 toggle k6", int'(tout), exp_toggle(6, 4));
    step(4);  check("R6 toggle k10", int'(tout), exp_toggle(10, 4));
    step(3);  check("R6 toggle k13", int'(tout), exp_toggle(13, 4));
    peek(3'd0, v); check("R3 period 4", v, exp_period(13, 4));
    wr(3'd3, 8'h00);

    // R6 both matches same cycle: B action last (A high, B low)
    wr(3'd4, 8'b0110); wr(3'd1, 8'd3); wr(3'd2, 8'd3); wr(3'd0, 8'd0); wr(3'd3, 8'h09);
    step(4); check("R6 B applied after A", int'(tout), 0);
    wr(3'd3, 8'h00);

    // R3 random periods
    for (int i = 0; i < 6; i++) begin
      p = 2 + int'($urandom % 150); k = int'($urandom % 400);
      wr(3'd3, 8'h00); wr(3'd1, 8'(p)); wr(3'd0, 8'd0); wr(3'd3, 8'h09);
      step(k); peek(3'd0, v); check("R3 random period", v, exp_period(k, p));
    end

    // R2 random free running
    for (int i = 0; i < 4; i++) begin
      s = int'($urandom % 256); k = int'($urandom % 300);
      wr(3'd3, 8'h00); wr(3'd0, 8'(s)); wr(3'd3, 8'h01);
      step(k); peek(3'd0, v); check("R2 random run", v, exp_wrap(s, k));
    end

    // R10 write wins over clear on A
    wr(3'd3, 8'h00); wr(3'd1, 8'd5); wr(3'd0, 8'd0); wr(3'd3, 8'h09);
    step(3); wr(3'd0, 8'd100);
    peek(3'd0, v); check("R10 write wins", v, 100);
    step(1); peek(3'd0, v); check("R10 continues", v, 101);
    wr(3'd3, 8'h00);

    // R5 external reset
    wr(3'd0, 8'd77); wr(3'd3, 8'h18);
    erst = 1'b1; step(4); erst = 1'b0; step(2);
    peek(3'd0, v); check("R5 ext clear", v, 0);
    wr(3'd0, 8'd77); wr(3'd3, 8'h08);
    erst = 1'b1; step(4); erst = 1'b0; step(2);
    peek(3'd0, v); check("R5 ignored in other mode", v, 77);
    wr(3'd3, 8'h00);

    // R11 trigger gate
    wr(3'd0, 8'd0); wr(3'd3, 8'h21); step(10);
    peek(3'd0, v); check("R11 held before trigger", v, 0);
    etrig = 1'b1; step(2); etrig = 1'b0; step(18);
    peek(3'd0, v); check("R11 count after trigger", v, 17);
    wr(3'd3, 8'h00);

    // R12 source selection
    wr(3'd0, 8'd0); wr(3'd3, 8'h05);
    for (int i = 0; i < 10; i++) begin eclk = 1'b1; step(4); eclk = 1'b0; step(4); end
    step(4); peek(3'd0, v); check("R12 ext rising", v, 10);
    wr(3'd3, 8'h00); wr(3'd0, 8'd0); wr(3'd3, 8'h07);
    for (int i = 0; i < 5; i++) begin eclk = 1'b1; step(4); eclk = 1'b0; step(4); end
    step(4); peek(3'd0, v); check("R12 ext both edges", v, 10);
    wr(3'd3, 8'h00); wr(3'd0, 8'd0); wr(3'd3, 8'h02);
    step(20); peek(3'd0, v); check("R12 idle tick1", v, 0);
    tick = 4'b0010; step(20);
    peek(3'd0, v); check("R12 tick1 counts", v, 20);
    t = 0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule